// File: doc/BRIEF.md
# Timebase Load Sequencer

This block is the per-thread timebase facility of a core. It keeps a 64-bit timebase and walks a small state machine that brings the timebase from an unset condition to a value taken from the chip time-of-day (TOD) logic. Software drives the machine through one 64-bit mode register. The low 16 bits hold the step timing configuration. Two command bits, which hardware clears, first arm the timebase and then ask it to take the TOD value. A read-only state field reports progress.

Once it is armed, the machine waits for a sync boundary. A sync boundary occurs when a selected bit of a free-running count of TOD step pulses toggles. It then takes the next 64-bit TOD transfer as the new timebase value. From there the timebase advances by one on every step pulse. Arming must see a step pulse within a configured number of clocks, or the request times out and the machine drops back to its idle state.

Top module: `tbase_load_fsm`

## Requirements
- R1: After reset the timebase is 0 and the mode register reads 0: state code 0, both commands clear, configuration 0, timeout flag clear.
- R2: A write stores bits [15:0] of the data as configuration, which reads back unchanged. The fields are: [7:0] arm step limit L, [11:8] clocks-per-step setting (stored only), [15:12] sync select S. Bits that are not defined read 0. The state field is [63:60] with codes idle=0, armed=1, sync-wait=2, fetch=3, run=4.
- R3: Writing 1 to bit 16 in idle moves the state to armed and bit 16 reads 1. The first step pulse after that clears bit 16 and leaves the state armed.
- R4: If no step pulse arrives on any of the L+1 clock edges that follow an arm write, bit 16 clears, bit 54 (timeout) sets and the state returns to idle. A write with bit 54 = 1 clears bit 54.
- R5: Writing 1 to bit 18 in armed with bit 16 already clear moves the state to sync-wait and bit 18 reads 1.
- R6: In sync-wait, the state moves to fetch on the step pulse that makes bit S of the step count toggle. The step count is the number of step pulses since reset, modulo 2^16. Steps before that pulse leave the state in sync-wait.
- R7: In fetch, a TOD transfer loads its value into the timebase, moves the state to run and clears bit 18, all at the same edge.
- R8: In run, each step pulse adds 1 to the timebase.
- R9: A transfer outside fetch leaves the timebase unchanged. Step pulses outside run do not advance it. A command bit written in the wrong state is ignored.
- R10: A write with bits 16 and 18 both 0 returns the state to idle and clears both commands, while the timebase holds its value.
- R11: Bit 51 of the mode register follows the TOD interrupt-pending input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_wr_en | input | 1 | Mode register write strobe |
| mode_wr_data | input | 64 | Mode register write data |
| mode_rd_data | output | 64 | Mode register contents |
| step_pulse | input | 1 | TOD step pulse, one cycle |
| tod_xfer_valid | input | 1 | TOD value transfer strobe |
| tod_xfer_value | input | 64 | TOD value carried by the transfer |
| tod_irq_pending | input | 1 | TOD interrupt pending |
| tb_value | output | 64 | Current timebase |

## Verification
The full load sequence runs once for each sync select from 0 to 3. The step count is left at different residues each time, so the number of steps spent in sync-wait varies. This separates a correct toggle detector from one that fires on the wrong bit or on every step. The arm timeout is swept over limits 0 to 3 and sampled one edge before and one edge at expiry, which exposes an off-by-one in the guard counter. Transfers, steps and command writes are also applied in states where they must be ignored, and the bench checks that the timebase and the state field do not change.

// File: rtl/tbf_pkg.sv
package tbf_pkg;
   typedef enum logic [3:0] {
      ST_IDLE      = 4'd0,
      ST_ARMED     = 4'd1,
      ST_SYNC_WAIT = 4'd2,
      ST_FETCH     = 4'd3,
      ST_RUN       = 4'd4
   } tbf_state_e;

   localparam int MODE_W   = 64;
   localparam int CFG_W    = 16;
   localparam int BIT_LOAD = 16;
   localparam int BIT_MOVE = 18;
   localparam int BIT_IRQ  = 51;
   localparam int BIT_TMO  = 54;
   localparam int ST_LSB   = 60;
   localparam int SEL_LSB  = 12;
endpackage

// File: rtl/tbf_sync_det.sv
module tbf_sync_det #(
   parameter int SEL_W     = 4,
   parameter bit RISE_ONLY = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic [SEL_W-1:0] sel,
   output logic             sync_o
);
   localparam int CNT_W = 1 << SEL_W;

   logic [CNT_W-1:0] cnt_q, cnt_nxt;

   assign cnt_nxt = cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};

   always_ff @(posedge clk) begin
      if (!rst_n)     cnt_q <= '0;
      else if (step)  cnt_q <= cnt_nxt;
   end

   generate
      if (RISE_ONLY) begin : g_rise
         assign sync_o = step & ~cnt_q[sel] & cnt_nxt[sel];
      end else begin : g_toggle
         assign sync_o = step & (cnt_q[sel] ^ cnt_nxt[sel]);
      end
   endgenerate

   // R6: a boundary is only ever reported on a step pulse
   p_sync_on_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      sync_o |=> (cnt_q != $past(cnt_q)));
endmodule

// File: rtl/tbf_guard_timer.sv
module tbf_guard_timer #(
   parameter int LIMIT_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic               pending,
   input  logic               step,
   input  logic [LIMIT_W-1:0] limit,
   output logic               expire_o
);
   logic [LIMIT_W-1:0] tcnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         tcnt_q <= '0;
      else if (start)
         tcnt_q <= '0;
      else if (pending && !step && tcnt_q != limit)
         tcnt_q <= tcnt_q + {{(LIMIT_W-1){1'b0}}, 1'b1};
   end

   assign expire_o = pending & ~step & ~start & (tcnt_q == limit);

   // R4: the wait count never moves while nothing is pending
   p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!pending && !start) |=> $stable(tcnt_q));
endmodule

// File: rtl/tbf_seq.sv
module tbf_seq
   import tbf_pkg::*;
#(
   parameter int TB_W = 64
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [CFG_W-1:0]    wr_cfg,
   input  logic                wr_load,
   input  logic                wr_move,
   input  logic                wr_tmo_clr,
   input  logic                step,
   input  logic                sync,
   input  logic                expire,
   input  logic                xfer_valid,
   input  logic [TB_W-1:0]     xfer_value,
   output logic [CFG_W-1:0]    cfg_o,
   output logic                load_o,
   output logic                move_o,
   output logic                tmo_o,
   output tbf_state_e          state_o,
   output logic [TB_W-1:0]     tb_o,
   output logic                load_start_o
);
   tbf_state_e state_q;
   logic       load_q, move_q, tmo_q;
   logic [CFG_W-1:0] cfg_q;
   logic [TB_W-1:0]  tb_q;

   assign load_start_o = wr_en & wr_load & (state_q == ST_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cfg_q   <= '0;
         load_q  <= 1'b0;
         move_q  <= 1'b0;
         tmo_q   <= 1'b0;
      end else if (wr_en) begin
         cfg_q <= wr_cfg;
         if (wr_tmo_clr) tmo_q <= 1'b0;
         if (wr_load && state_q == ST_IDLE) begin
            state_q <= ST_ARMED;
            load_q  <= 1'b1;
         end else if (wr_move && state_q == ST_ARMED && !load_q) begin
            state_q <= ST_SYNC_WAIT;
            move_q  <= 1'b1;
         end else if (!wr_load && !wr_move) begin
            state_q <= ST_IDLE;
            load_q  <= 1'b0;
            move_q  <= 1'b0;
         end
      end else begin
         case (state_q)
            ST_ARMED: begin
               if (load_q && step) begin
                  load_q <= 1'b0;
               end else if (load_q && expire) begin
                  load_q  <= 1'b0;
                  tmo_q   <= 1'b1;
                  state_q <= ST_IDLE;
               end
            end
            ST_SYNC_WAIT: if (sync) state_q <= ST_FETCH;
            ST_FETCH: begin
               if (xfer_valid) begin
                  state_q <= ST_RUN;
                  move_q  <= 1'b0;
               end
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         tb_q <= '0;
      else if (state_q == ST_FETCH && xfer_valid && !wr_en)
         tb_q <= xfer_value;
      else if (state_q == ST_RUN && step)
         tb_q <= tb_q + {{(TB_W-1){1'b0}}, 1'b1};
   end

   assign cfg_o   = cfg_q;
   assign load_o  = load_q;
   assign move_o  = move_q;
   assign tmo_o   = tmo_q;
   assign state_o = state_q;
   assign tb_o    = tb_q;

   p_state_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
      state_q inside {ST_IDLE, ST_ARMED, ST_SYNC_WAIT, ST_FETCH, ST_RUN});
   p_arm_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_ARMED && load_q && step && !wr_en) |=> (!load_q && state_q == ST_ARMED));
   p_timeout_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_ARMED && load_q && expire && !wr_en) |=> (tmo_q && state_q == ST_IDLE));
   p_boundary_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_SYNC_WAIT && sync && !wr_en) |=> (state_q == ST_FETCH));
   p_fetch_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_FETCH && xfer_valid && !wr_en) |=>
         (tb_q == $past(xfer_value) && state_q == ST_RUN && !move_q));
   p_run_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_RUN && step) |=> (tb_q == $past(tb_q) + 1'b1));
   p_tb_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_RUN && state_q != ST_FETCH) |=> $stable(tb_q));
endmodule

// File: rtl/tbase_load_fsm.sv
module tbase_load_fsm
   import tbf_pkg::*;
#(
   parameter int TB_W      = 64,
   parameter int SEL_W     = 4,
   parameter int LIMIT_W   = 8,
   parameter bit RISE_ONLY = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_wr_en,
   input  logic [MODE_W-1:0] mode_wr_data,
   output logic [MODE_W-1:0] mode_rd_data,
   input  logic              step_pulse,
   input  logic              tod_xfer_valid,
   input  logic [TB_W-1:0]   tod_xfer_value,
   input  logic              tod_irq_pending,
   output logic [TB_W-1:0]   tb_value
);
   generate
      if (SEL_W < 1 || SEL_W > 4) begin : g_bad_sel
         $error("SEL_W must be 1..4");
      end
      if (LIMIT_W < 1 || LIMIT_W > 8) begin : g_bad_lim
         $error("LIMIT_W must be 1..8");
      end
      if (TB_W < (1 << SEL_W)) begin : g_bad_tb
         $error("TB_W too narrow for the step counter");
      end
   endgenerate

   logic [CFG_W-1:0] cfg;
   logic             load_cmd, move_cmd, tmo_flag, load_start;
   logic             sync_hit, expire;
   tbf_state_e       state;
   logic             unused_wr_bits;

   assign unused_wr_bits = ^{mode_wr_data[63:55], mode_wr_data[53:19], mode_wr_data[17],
                             cfg[CFG_W-1:SEL_LSB+SEL_W], cfg[SEL_LSB-1:LIMIT_W]};

   tbf_sync_det #(.SEL_W(SEL_W), .RISE_ONLY(RISE_ONLY)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .step   (step_pulse),
      .sel    (cfg[SEL_LSB +: SEL_W]),
      .sync_o (sync_hit)
   );

   tbf_guard_timer #(.LIMIT_W(LIMIT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (load_start),
      .pending  (load_cmd),
      .step     (step_pulse),
      .limit    (cfg[LIMIT_W-1:0]),
      .expire_o (expire)
   );

   tbf_seq #(.TB_W(TB_W)) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_en        (mode_wr_en),
      .wr_cfg       (mode_wr_data[CFG_W-1:0]),
      .wr_load      (mode_wr_data[BIT_LOAD]),
      .wr_move      (mode_wr_data[BIT_MOVE]),
      .wr_tmo_clr   (mode_wr_data[BIT_TMO]),
      .step         (step_pulse),
      .sync         (sync_hit),
      .expire       (expire),
      .xfer_valid   (tod_xfer_valid),
      .xfer_value   (tod_xfer_value),
      .cfg_o        (cfg),
      .load_o       (load_cmd),
      .move_o       (move_cmd),
      .tmo_o        (tmo_flag),
      .state_o      (state),
      .tb_o         (tb_value),
      .load_start_o (load_start)
   );

   always_comb begin
      mode_rd_data                 = '0;
      mode_rd_data[CFG_W-1:0]      = cfg;
      mode_rd_data[BIT_LOAD]       = load_cmd;
      mode_rd_data[BIT_MOVE]       = move_cmd;
      mode_rd_data[BIT_IRQ]        = tod_irq_pending;
      mode_rd_data[BIT_TMO]        = tmo_flag;
      mode_rd_data[ST_LSB +: 4]    = state;
   end

   // R11: the interrupt flag tracks its input in every cycle
   p_irq_mirror_r11: assert property (@(posedge clk) disable iff (!rst_n)
      mode_rd_data[BIT_IRQ] == tod_irq_pending);
endmodule

// File: tb/tbase_load_fsm_test.sv
module tbase_load_fsm_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mode_wr_en = 1'b0;
   logic [63:0] mode_wr_data = '0;
   logic [63:0] mode_rd_data;
   logic        step_pulse = 1'b0;
   logic        tod_xfer_valid = 1'b0;
   logic [63:0] tod_xfer_value = '0;
   logic        tod_irq_pending = 1'b0;
   logic [63:0] tb_value;

   int checks = 0;
   int fails  = 0;
   int sc     = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   tbase_load_fsm uut (
      .clk(clk), .rst_n(rst_n), .mode_wr_en(mode_wr_en), .mode_wr_data(mode_wr_data),
      .mode_rd_data(mode_rd_data), .step_pulse(step_pulse), .tod_xfer_valid(tod_xfer_valid),
      .tod_xfer_value(tod_xfer_value), .tod_irq_pending(tod_irq_pending), .tb_value(tb_value)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [63:0] cfgw(input int lim, input int sel);
      return {48'd0, 4'(sel), 4'h2, 8'(lim)};
   endfunction

   task automatic wr(input logic [63:0] d);
      mode_wr_data = d; mode_wr_en = 1'b1;
      @(negedge clk);
      mode_wr_en = 1'b0; mode_wr_data = '0;
   endtask

   task automatic stp();
      step_pulse = 1'b1;
      @(negedge clk);
      step_pulse = 1'b0;
      sc = (sc + 1) % 65536;
   endtask

   task automatic xfer(input logic [63:0] v);
      tod_xfer_value = v; tod_xfer_valid = 1'b1;
      @(negedge clk);
      tod_xfer_valid = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   function automatic logic [63:0] st();
      return {60'd0, mode_rd_data[63:60]};
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      logic [63:0] v;
      int n, k;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 mode reg after reset", mode_rd_data, 64'd0);
      chk("R1 timebase after reset", tb_value, 64'd0);

      tod_irq_pending = 1'b1; #1;
      chk("R11 irq bit set", {63'd0, mode_rd_data[51]}, 64'd1);
      tod_irq_pending = 1'b0; #1;
      chk("R11 irq bit clear", {63'd0, mode_rd_data[51]}, 64'd0);

      wr(64'h0000_0100_0000_3A05);
      chk("R2 config readback", mode_rd_data, 64'h0000_0000_0000_3A05);

      // R9: move command in idle is ignored, transfer in idle ignored
      wr(cfgw(5, 0) | (64'd1 << 18));
      chk("R9 move in idle ignored state", st(), 64'd0);
      chk("R9 move in idle ignored bit", {63'd0, mode_rd_data[18]}, 64'd0);
      xfer(64'h1111_2222_3333_4444);
      chk("R9 xfer in idle ignored", tb_value, 64'd0);

      // R4 timeout sweep
      for (int m = 0; m < 4; m++) begin
         wr(cfgw(m, 0) | (64'd1 << 16));
         idle(m);
         chk($sformatf("R4 pending before expiry m=%0d", m), st(), 64'd1);
         chk($sformatf("R3 arm bit pending m=%0d", m), {63'd0, mode_rd_data[16]}, 64'd1);
         idle(1);
         chk($sformatf("R4 timeout flag m=%0d", m), {63'd0, mode_rd_data[54]}, 64'd1);
         chk($sformatf("R4 back to idle m=%0d", m), st(), 64'd0);
         chk($sformatf("R4 arm bit cleared m=%0d", m), {63'd0, mode_rd_data[16]}, 64'd0);
         wr(cfgw(m, 0) | (64'd1 << 54));
         chk($sformatf("R4 timeout flag w1c m=%0d", m), {63'd0, mode_rd_data[54]}, 64'd0);
      end

      // main sequence per sync select
      for (int sel = 0; sel < 4; sel++) begin
         wr(cfgw(200, sel) | (64'd1 << 16));
         chk($sformatf("R3 armed s=%0d", sel), st(), 64'd1);
         v = tb_value;
         stp();
         chk($sformatf("R3 arm bit cleared by step s=%0d", sel), {63'd0, mode_rd_data[16]}, 64'd0);
         chk($sformatf("R3 still armed s=%0d", sel), st(), 64'd1);
         chk($sformatf("R9 step outside run s=%0d", sel), tb_value, v);
         wr(cfgw(200, sel) | (64'd1 << 16));
         chk($sformatf("R9 arm in armed ignored s=%0d", sel), st(), 64'd1);
         chk($sformatf("R9 arm bit stays clear s=%0d", sel), {63'd0, mode_rd_data[16]}, 64'd0);
         wr(cfgw(200, sel) | (64'd1 << 18));
         chk($sformatf("R5 sync-wait s=%0d", sel), st(), 64'd2);
         chk($sformatf("R5 move bit set s=%0d", sel), {63'd0, mode_rd_data[18]}, 64'd1);
         n = 1;
         while (((sc + n) % (1 << sel)) != 0) n++;
         for (int i = 0; i < n - 1; i++) stp();
         chk($sformatf("R6 waiting before boundary s=%0d n=%0d", sel, n), st(), 64'd2);
         xfer(64'hFFFF_0000_FFFF_0000);
         chk($sformatf("R9 xfer in sync-wait ignored s=%0d", sel), tb_value, v);
         stp();
         chk($sformatf("R6 fetch at boundary s=%0d", sel), st(), 64'd3);
         v = 64'hC0DE_0000_1234_0000 + 64'(sel * 64'h1_0000_0001);
         xfer(v);
         chk($sformatf("R7 tb loaded s=%0d", sel), tb_value, v);
         chk($sformatf("R7 run state s=%0d", sel), st(), 64'd4);
         chk($sformatf("R7 move bit cleared s=%0d", sel), {63'd0, mode_rd_data[18]}, 64'd0);
         k = sel + 2;
         for (int i = 0; i < k; i++) stp();
         chk($sformatf("R8 tb advanced s=%0d", sel), tb_value, v + 64'(k));
         xfer(64'h0);
         chk($sformatf("R9 xfer in run ignored s=%0d", sel), tb_value, v + 64'(k));
         wr(cfgw(200, sel));
         chk($sformatf("R10 idle after plain write s=%0d", sel), st(), 64'd0);
         chk($sformatf("R10 tb held s=%0d", sel), tb_value, v + 64'(k));
         stp();
         chk($sformatf("R9 step in idle s=%0d", sel), tb_value, v + 64'(k));
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule